// File: doc/BRIEF.md
# Timing Pulse and Interval Interrupt Generator

This block drives a single active-low timing-pulse level, `tp_n`, for a real-time-clock subsystem. A free-running binary prescaler counts enables from the 32.768 kHz oscillator domain. Taps on the prescaler give four selectable square waves. The same prescaler also produces a 64 Hz tick. That tick clocks an interval counter, which raises an interrupt flag once per chosen period of 1, 10, 30 or 60 seconds. The flag pulls `tp_n` low.

The decoded command strobes come from the command decoder outside this block. They select a frequency or an interval, clear the flag, and stop or resume the interval clock. Selecting an interval clears the counter and starts it. Clearing the flag leaves the counter running. If nobody clears the flag, it drops again at mid-period, so the interval output becomes a 50 % duty wave. A test-mode override replaces the output while the surrounding register block is under test. The interval counter has no link to the calendar counters.

Top module: `tp_pulse_gen`

## Requirements
- R1: While `rst_n` is low, the prescaler count is zero and the output source is the 64 Hz wave, so `tp_n` is 0. In that state the interval timer is stopped with a count of 0 and the flag is clear.
- R2: In frequency mode, `tp_n` is the square wave picked by the `freq_sel` value latched on `cmd_freq`: 0 gives 64 Hz, 1 gives 256 Hz, 2 gives 2048 Hz and 3 gives 4096 Hz. Each wave is low for the first half of its period in oscillator ticks, counted from reset. A change of `freq_sel` without `cmd_freq` has no effect.
- R3: `cmd_ivl` latches `ivl_sel`, clears the interval count and the flag, starts the timer, and switches `tp_n` to the interval source (`tp_n` = NOT flag).
- R4: The flag sets, and `tp_n` goes low, each time the running counter reaches `TICKS_PER_SEC`·N ticks of the 64 Hz tick. N is 1, 10, 30 or 60 for `ivl_sel` values 0, 1, 2 and 3. The counter then restarts from 0.
- R5: When the running counter reaches half the period, the flag clears. An uncleared interval output therefore has a 50 % duty cycle.
- R6: `cmd_flag_clr` clears only the flag. The counter keeps counting, and the next set comes at the same period boundary as before.
- R7: `cmd_stop` freezes the count and the flag. `cmd_run` resumes counting from the frozen count.
- R8: The 64 Hz tick occurs on every 2^(`OSC_LOG2`−6)-th oscillator enable, when the low prescaler bits are all ones.
- R9: While `test_active` is 1, `reg_op` overrides `tp_n`. Value 0 (hold) gives 64 Hz. Values 1 (shift) and 3 (read) give 32 Hz. Value 2 (set) holds `tp_n` at 0.
- R10: Strobes that arrive in the same cycle resolve as follows. `cmd_ivl` overrides all other strobes. `cmd_stop` beats `cmd_run`. `cmd_flag_clr` beats a flag set at a period boundary in that cycle. Stop and run take effect from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable per 32.768 kHz oscillator period |
| cmd_freq | input | 1 | Strobe: latch `freq_sel`, select frequency source |
| freq_sel | input | 2 | Frequency code (64/256/2048/4096 Hz) |
| cmd_ivl | input | 1 | Strobe: latch `ivl_sel`, clear and start interval timer |
| ivl_sel | input | 2 | Interval code (1/10/30/60 s) |
| cmd_flag_clr | input | 1 | Strobe: clear the interval flag only |
| cmd_run | input | 1 | Strobe: resume the interval clock |
| cmd_stop | input | 1 | Strobe: halt the interval clock |
| test_active | input | 1 | Test override enable |
| reg_op | input | 2 | Register operation under test (0 hold, 1 shift, 2 set, 3 read) |
| tp_n | output | 1 | Active-low timing pulse level |

## Verification
The hardest state to reach from the ports is a long interval period observed across a full wrap with nobody clearing the flag. At the true tick rate a 60 s period would take about two million oscillator enables. The bench therefore shrinks `TICKS_PER_SEC` to 2 and drives `osc_tick` on every cycle, which keeps the prescaler taps at their real ratios while a full 60 s period fits inside the run. A flag clear timed inside the short low window of the 1 s setting, and a stop held across several ticks, are found by waiting for `tp_n` to fall before issuing the strobe.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_SET   = 2'd2,
    OP_READ  = 2'd3
  } reg_op_e;

  typedef enum logic {
    SRC_FREQ = 1'b0,
    SRC_IVL  = 1'b1
  } tp_src_e;

  // Interval length in seconds for an interval code.
  function automatic int unsigned ivl_secs(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 10;
      2'd2:    return 30;
      default: return 60;
    endcase
  endfunction

  // Interval length in 64 Hz ticks (scaled by ticks per second).
  function automatic int unsigned ivl_period(input logic [1:0] sel,
                                             input int unsigned tps);
    return tps * ivl_secs(sel);
  endfunction

  // log2 of the output frequency for a frequency code.
  function automatic int unsigned freq_log2(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6;
      2'd1:    return 8;
      2'd2:    return 11;
      default: return 12;
    endcase
  endfunction

  // Prescaler bit whose level is a square wave of 2^flog2 Hz.
  function automatic int unsigned tap_for_log2(input int unsigned flog2,
                                               input int unsigned osc_log2);
    return osc_log2 - 1 - flog2;
  endfunction

endpackage

// File: rtl/tp_prescaler.sv
module tp_prescaler #(
  parameter int unsigned OSC_LOG2 = 15,
  parameter int unsigned DIV_W    = OSC_LOG2 - 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  output logic [DIV_W-1:0] div_q,
  output logic             tick64
);
  localparam int unsigned SUB_W = OSC_LOG2 - 6;

  assign tick64 = osc_tick && (&div_q[SUB_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (osc_tick) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tp_interval.sv
module tp_interval
  import tp_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 64,
  parameter int unsigned CNT_W         = $clog2(TICKS_PER_SEC * 60 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick64,
  input  logic             cmd_ivl,
  input  logic [1:0]       ivl_sel,
  input  logic             cmd_flag_clr,
  input  logic             cmd_run,
  input  logic             cmd_stop,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             run_q,
  output logic             ivl_half,
  output logic             ivl_wrap
);
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt_nx;
  logic             step;
  logic             flag_nx;

  assign period = CNT_W'(ivl_period(sel_q, TICKS_PER_SEC));
  assign half   = period >> 1;
  assign cnt_nx = cnt_q + 1'b1;
  assign step   = run_q && tick64 && !cmd_ivl;

  assign ivl_half = step && (cnt_nx == half);
  assign ivl_wrap = step && (cnt_nx == period);

  always_comb begin
    flag_nx = flag_q;
    if (ivl_wrap)      flag_nx = 1'b1;
    else if (ivl_half) flag_nx = 1'b0;
    if (cmd_flag_clr)  flag_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (cmd_ivl) begin
      sel_q  <= ivl_sel;
      cnt_q  <= '0;
      flag_q <= 1'b0;
      run_q  <= 1'b1;
    end else begin
      if (step) cnt_q <= ivl_wrap ? '0 : cnt_nx;
      flag_q <= flag_nx;
      if (cmd_stop)     run_q <= 1'b0;
      else if (cmd_run) run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tp_out_select.sv
module tp_out_select
  import tp_pkg::*;
#(
  parameter int unsigned OSC_LOG2 = 15,
  parameter int unsigned DIV_W    = OSC_LOG2 - 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_freq,
  input  logic [1:0]       freq_sel,
  input  logic             cmd_ivl,
  input  logic [DIV_W-1:0] div_q,
  input  logic             flag_q,
  input  logic             test_active,
  input  logic [1:0]       reg_op,
  output logic             tp_n
);
  localparam int unsigned TAP_64 = tap_for_log2(6, OSC_LOG2);
  localparam int unsigned TAP_32 = tap_for_log2(5, OSC_LOG2);

  tp_src_e    src_q;
  logic [1:0] fsel_q;
  logic       freq_wave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_FREQ;
      fsel_q <= '0;
    end else if (cmd_ivl) begin
      src_q  <= SRC_IVL;
    end else if (cmd_freq) begin
      src_q  <= SRC_FREQ;
      fsel_q <= freq_sel;
    end
  end

  assign freq_wave = div_q[tap_for_log2(freq_log2(fsel_q), OSC_LOG2)];

  always_comb begin
    if (test_active) begin
      case (reg_op_e'(reg_op))
        OP_HOLD: tp_n = div_q[TAP_64];
        OP_SET:  tp_n = 1'b0;
        default: tp_n = div_q[TAP_32];
      endcase
    end else if (src_q == SRC_IVL) begin
      tp_n = ~flag_q;
    end else begin
      tp_n = freq_wave;
    end
  end
endmodule

// File: rtl/tp_pulse_gen.sv
module tp_pulse_gen #(
  parameter int unsigned OSC_LOG2      = 15,
  parameter int unsigned TICKS_PER_SEC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       cmd_freq,
  input  logic [1:0] freq_sel,
  input  logic       cmd_ivl,
  input  logic [1:0] ivl_sel,
  input  logic       cmd_flag_clr,
  input  logic       cmd_run,
  input  logic       cmd_stop,
  input  logic       test_active,
  input  logic [1:0] reg_op,
  output logic       tp_n
);
  localparam int unsigned DIV_W     = OSC_LOG2 - 5;
  localparam int unsigned MAX_TICKS = TICKS_PER_SEC * 60;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic [DIV_W-1:0] div_q;
  logic             tick64;
  logic [CNT_W-1:0] ivl_cnt;
  logic             ivl_flag;
  logic             ivl_run;
  logic             ivl_half;
  logic             ivl_wrap;

  tp_prescaler #(.OSC_LOG2(OSC_LOG2), .DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .div_q(div_q), .tick64(tick64)
  );

  tp_interval #(.TICKS_PER_SEC(TICKS_PER_SEC), .CNT_W(CNT_W)) u_ivl (
    .clk(clk), .rst_n(rst_n), .tick64(tick64),
    .cmd_ivl(cmd_ivl), .ivl_sel(ivl_sel), .cmd_flag_clr(cmd_flag_clr),
    .cmd_run(cmd_run), .cmd_stop(cmd_stop),
    .cnt_q(ivl_cnt), .flag_q(ivl_flag), .run_q(ivl_run),
    .ivl_half(ivl_half), .ivl_wrap(ivl_wrap)
  );

  tp_out_select #(.OSC_LOG2(OSC_LOG2), .DIV_W(DIV_W)) u_out (
    .clk(clk), .rst_n(rst_n), .cmd_freq(cmd_freq), .freq_sel(freq_sel),
    .cmd_ivl(cmd_ivl), .div_q(div_q), .flag_q(ivl_flag),
    .test_active(test_active), .reg_op(reg_op), .tp_n(tp_n)
  );
endmodule

// File: rtl/tp_pulse_gen_chk.sv
module tp_pulse_gen_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick64,
  input logic             ivl_half,
  input logic             ivl_wrap,
  input logic             cmd_ivl,
  input logic             cmd_flag_clr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_q,
  input logic             run_q,
  input logic             test_active,
  input logic [1:0]       reg_op,
  input logic             tp_n
);
  assert_select_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ivl |=> (cnt_q == '0) && !flag_q && run_q);

  assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ivl_wrap && !cmd_flag_clr) |=> flag_q);

  assert_half_drops_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_half |=> !flag_q);

  assert_clear_only_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_flag_clr && !cmd_ivl) |=> !flag_q);

  assert_stop_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmd_ivl) |=> $stable(cnt_q));

  assert_tick_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick64 |=> !tick64);

  assert_test_set_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (test_active && reg_op == 2'd2) |-> !tp_n);
endmodule

bind tp_pulse_gen tp_pulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick64(tick64),
  .ivl_half(ivl_half), .ivl_wrap(ivl_wrap),
  .cmd_ivl(cmd_ivl), .cmd_flag_clr(cmd_flag_clr),
  .cnt_q(ivl_cnt), .flag_q(ivl_flag), .run_q(ivl_run),
  .test_active(test_active), .reg_op(reg_op), .tp_n(tp_n)
);

// File: tb/sim_tp_pulse_gen.sv
module sim_tp_pulse_gen;
  localparam int PERIOD   = 10;
  localparam int OSC_LOG2 = 15;
  localparam int TPS      = 2;
  localparam int OSC_HZ   = 1 << OSC_LOG2;
  localparam int TICK_DIV = OSC_HZ / 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b1;
  logic cmd_freq = 1'b0, cmd_ivl = 1'b0, cmd_flag_clr = 1'b0;
  logic cmd_run = 1'b0, cmd_stop = 1'b0, test_active = 1'b0;
  logic [1:0] freq_sel = 2'd0, ivl_sel = 2'd0, reg_op = 2'd0;
  logic tp_n;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  tp_pulse_gen #(.OSC_LOG2(OSC_LOG2), .TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .cmd_freq(cmd_freq), .freq_sel(freq_sel),
    .cmd_ivl(cmd_ivl), .ivl_sel(ivl_sel), .cmd_flag_clr(cmd_flag_clr),
    .cmd_run(cmd_run), .cmd_stop(cmd_stop),
    .test_active(test_active), .reg_op(reg_op), .tp_n(tp_n)
  );

  // ---------------- behavioural reference ----------------
  int hz_tab[4]   = '{64, 256, 2048, 4096};
  int secs_tab[4] = '{1, 10, 30, 60};
  longint ocount;
  int  mcnt, msel, mfsel;
  bit  mflag, mrun, msrc;

  function automatic bit sq(input int hz);
    int p;
    p = OSC_HZ / hz;
    return ((ocount % p) >= (p / 2));
  endfunction

  function automatic bit expect_tp();
    if (test_active) begin
      if (reg_op == 2'd2) return 1'b0;
      if (reg_op == 2'd0) return sq(64);
      return sq(32);
    end
    if (msrc) return !mflag;
    return sq(hz_tab[mfsel]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocount = 0; mcnt = 0; msel = 0; mfsel = 0;
      mflag = 0; mrun = 0; msrc = 0;
    end else begin
      bit tick;
      int per;
      tick = osc_tick && ((ocount % TICK_DIV) == TICK_DIV - 1);
      if (osc_tick) ocount++;
      if (cmd_ivl) begin
        msrc = 1; msel = ivl_sel; mcnt = 0; mflag = 0; mrun = 1;
      end else begin
        per = TPS * secs_tab[msel];
        if (mrun && tick) begin
          mcnt++;
          if (mcnt == per / 2) mflag = 0;
          if (mcnt == per) begin mflag = 1; mcnt = 0; end
        end
        if (cmd_flag_clr) mflag = 0;
        if (cmd_stop) mrun = 0;
        else if (cmd_run) mrun = 1;
        if (cmd_freq) begin msrc = 0; mfsel = freq_sel; end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      bit e;
      e = expect_tp();
      checks++;
      if (tp_n !== e) begin
        errors++;
        $display("FAIL %s: tp_n=%b expected %b at ocount=%0d", phase, tp_n, e, ocount);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_freq(input logic [1:0] s);
    @(negedge clk); freq_sel = s; cmd_freq = 1;
    @(negedge clk); cmd_freq = 0;
  endtask

  task automatic do_ivl(input logic [1:0] s);
    @(negedge clk); ivl_sel = s; cmd_ivl = 1;
    @(negedge clk); cmd_ivl = 0;
  endtask

  task automatic do_ctl(input bit clr, input bit run, input bit stop);
    @(negedge clk); cmd_flag_clr = clr; cmd_run = run; cmd_stop = stop;
    @(negedge clk); cmd_flag_clr = 0; cmd_run = 0; cmd_stop = 0;
  endtask

  // Wait (sampling after negedge) until tp_n equals v; returns cycles waited.
  task automatic wait_tp(input logic v, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk); #2;
      if (tp_n === v) break;
      n++;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n, m;
    // R1: reset state
    idle(3); #1;
    check("R1", tp_n, 0);
    @(negedge clk); rst_n = 1;
    phase = "R1"; idle(600);

    // R2: each frequency, then a select change without strobe
    phase = "R2";
    for (int f = 0; f < 4; f++) begin do_freq(f[1:0]); idle(1500); end
    @(negedge clk); freq_sel = 2'd0; idle(1000);

    // R9: test override for each register operation
    phase = "R9";
    test_active = 1;
    for (int op = 0; op < 4; op++) begin reg_op = op[1:0]; idle(1100); end
    test_active = 0; reg_op = 0;

    // R3/R4/R8: 1 s interval, fall-to-fall spacing
    phase = "R3"; do_ivl(2'd0);
    check("R3", tp_n, 1);
    phase = "R4";
    wait_tp(1'b0, 3000, n);
    wait_tp(1'b1, 3000, n);
    wait_tp(1'b0, 3000, n);
    wait_tp(1'b1, 3000, m);
    check("R5", m + 1, TPS * TICK_DIV / 2);
    wait_tp(1'b0, 3000, n);
    check("R8", n + m + 2, TPS * TICK_DIV);

    // R6: clear flag during its low window, timer keeps schedule
    phase = "R6";
    idle(50); do_ctl(1, 0, 0);
    #2; check("R6", tp_n, 1);
    idle(3000);

    // R7: stop freezes, run resumes
    phase = "R7";
    do_ctl(0, 0, 1); idle(3000);
    do_ctl(0, 1, 0); idle(3000);

    // R10: simultaneous strobes
    phase = "R10";
    @(negedge clk); ivl_sel = 0; cmd_ivl = 1; cmd_stop = 1; cmd_freq = 1;
    @(negedge clk); cmd_ivl = 0; cmd_stop = 0; cmd_freq = 0;
    idle(2000);
    do_ctl(0, 1, 1); idle(1500);
    do_ctl(0, 1, 0); idle(1500);

    // R5: 10 s duty, then 30 s and 60 s periods
    phase = "R5"; do_ivl(2'd1);
    wait_tp(1'b0, 12000, n);
    wait_tp(1'b1, 12000, m);
    check("R5", m + 1, 10 * TPS * TICK_DIV / 2);
    phase = "R4"; do_ivl(2'd2); idle(31500);
    do_ivl(2'd3);
    wait_tp(1'b0, 62000, n);
    check("R4", (n + 1 > 60 * TPS * TICK_DIV - TICK_DIV) ? 1 : 0, 1);
    idle(200);
    summary();
  end
endmodule